// File: doc/BRIEF.md
# Prescaled Interval Timer with Compare Flags

This block is a general-purpose interval timer. A programmable prescaler divides the input clock, and each prescaled tick advances a counter. The counter runs between zero and a reload value. It can count upward and wrap, count downward and reload, or sweep up and then down in center-aligned fashion. A flag vector reports timer events. Bit 0 is the update flag, set at each wrap or turnaround. Bits 1 to NCH are the compare flags, one per compare channel.

Hardware sets flags and they stay set. Software clears them through a one-cycle write port that clears a flag wherever the written bit is 0. The compare logic covers two corner cases. A compare value above the reload value can never be matched by the count, so its flag is raised at the counter's overflow or underflow instead. A compare value of zero in center-aligned mode never raises its flag.

Top module: `cmp_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the prescaler state and every flag become zero. The center-aligned sweep restarts in its upward phase.
- R2: With prescale value P, the counter advances once every P+1 enabled clock cycles. P = 0xFFFF is allowed. After reset and enable, the first advance is seen after P+1 clock edges.
- R3: Edge-aligned up counting is `mode`=00 with `dir_down`=0. The count rises by one per tick and never exceeds `reload` from a reset start. On the tick where count >= `reload` it returns to 0 and sets flag bit 0 (overflow).
- R4: Edge-aligned down counting is `mode`=00 with `dir_down`=1. The count falls by one per tick. On the tick where it is 0 it loads `reload` and sets flag bit 0 (underflow).
- R5: Center-aligned mode is any nonzero `mode`; `dir_down` is ignored there. The count rises from 0 to `reload`, then falls to 0, and repeats. Flag bit 0 is set at both the top turnaround (overflow) and the bottom turnaround (underflow).
- R6: For channel k with `cmp_val[16k+15:16k]` <= `reload`, flag bit k+1 is set on every tick where the count equals that compare value, in either direction.
- R7: For a channel whose compare value exceeds `reload`, flag bit k+1 is set on overflow in up and center-aligned modes, and on underflow in down mode.
- R8: In center-aligned mode a channel with compare value 0 never sets its flag.
- R9: When `sts_we` is 1, each flag whose `sts_wdata` bit is 0 is cleared. A bit written 1 leaves its flag unchanged.
- R10: If hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R11: While `enable` is 0, the count and the prescaler hold their values and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low freezes the timer |
| mode | input | 2 | 00 edge-aligned, nonzero center-aligned |
| dir_down | input | 1 | Direction in edge-aligned mode (1 = down) |
| psc | input | 16 | Prescale value P; tick rate is clk/(P+1) |
| reload | input | 16 | Counter reload (top) value |
| cmp_val | input | 64 | Four 16-bit compare values, channel k in bits 16k+15:16k |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 5 | Status write data; 0 clears the matching flag |
| count | output | 16 | Current counter value |
| flags | output | 5 | Bit 0 update, bit k+1 compare channel k |

## Verification
The hardest case to reach from the ports is a hardware set that lands in the same cycle as a software clear. The bench holds a clear-all write active across a whole center-aligned run, so every compare and turnaround event coincides with a clear. It also drives compare values of zero and values above the reload in every counting style. The prescaler limit is reached with P = 0xFFFF, and the bench checks the exact edge of the first advance.

// File: rtl/tmr_pkg.sv
// Package: shared constants and helpers for the prescaled timer.
// Assumes the mode encoding 00 = edge-aligned, any other value = center.
package tmr_pkg;
    localparam int unsigned MODE_W = 2;

    // Returns 1 when the mode field selects center-aligned counting.
    function automatic logic is_center(input logic [MODE_W-1:0] m);
        return (m != '0);
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Module: clock prescaler. It raises a one-cycle tick every PSC+1 enabled
// cycles. Assumes psc may change at any time; a state above psc wraps at once.
module tmr_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;

    // Tick when the divider reaches its limit while running.
    always_comb tick = en && (pcnt >= psc);

    // Advance or wrap the divider; hold it while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)   pcnt <= '0;
        else if (en)  pcnt <= tick ? '0 : pcnt + 1'b1;
    end

    a_r11_psc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pcnt));
    a_r2_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt == '0));
endmodule

// File: rtl/tmr_counter.sv
// Module: main counter. It moves once per tick in up, down or center-aligned
// style and reports overflow and underflow events in the tick cycle.
// Assumes tick comes from the prescaler and is 0 while disabled.
module tmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             center,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt,
    output logic             udf_evt
);
    logic             up_ph;
    logic [CNT_W-1:0] cnt_nx;
    logic             up_nx;

    // Next count and sweep phase for the selected counting style.
    always_comb begin
        cnt_nx  = cnt;
        up_nx   = up_ph;
        ovf_evt = 1'b0;
        udf_evt = 1'b0;
        if (tick) begin
            if (center) begin
                if (up_ph) begin
                    if (cnt >= reload) begin
                        ovf_evt = 1'b1;
                        if (reload == '0) begin
                            cnt_nx = '0;
                        end else begin
                            cnt_nx = reload - 1'b1;
                            up_nx  = 1'b0;
                        end
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end else begin
                    if (cnt == '0) begin
                        udf_evt = 1'b1;
                        cnt_nx  = (reload == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
                        up_nx   = 1'b1;
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
            end else if (dir_down) begin
                if (cnt == '0) begin
                    udf_evt = 1'b1;
                    cnt_nx  = reload;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end else begin
                if (cnt >= reload) begin
                    ovf_evt = 1'b1;
                    cnt_nx  = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
        end
        if (!center) up_nx = 1'b1;
    end

    // Register count and sweep phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            up_ph <= 1'b1;
        end else begin
            cnt   <= cnt_nx;
            up_ph <= up_nx;
        end
    end

    a_r11_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !center && !dir_down && cnt >= reload) |=> (cnt == '0));
    a_r4_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !center && dir_down && cnt == '0) |=> (cnt == $past(reload)));
    a_r5_bottom_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_evt && center && reload != '0) |=> (cnt == 1 && up_ph));
endmodule

// File: rtl/tmr_compare.sv
// Module: compare channels. Each channel makes a one-cycle set pulse for its
// flag. Assumes events and tick are valid in the same cycle as the old count.
module tmr_compare #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned NCH   = 4
) (
    input  logic                 tick,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [NCH*CNT_W-1:0] cmp_vec,
    input  logic [CNT_W-1:0]     reload,
    input  logic                 center,
    input  logic                 dir_down,
    input  logic                 ovf_evt,
    input  logic                 udf_evt,
    output logic [NCH-1:0]       set
);
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic [CNT_W-1:0] cv;
        logic             beyond;
        assign cv     = cmp_vec[k*CNT_W +: CNT_W];
        assign beyond = (cv > reload);

        // Match in range, or fall back to the wrap event when out of range.
        always_comb begin
            if (center && cv == '0)        set[k] = 1'b0;
            else if (beyond)               set[k] = (center || !dir_down) ? ovf_evt : udf_evt;
            else                           set[k] = tick && (cnt == cv);
        end
    end
endmodule

// File: rtl/tmr_flags.sv
// Module: sticky status flags. Hardware sets them; a write with a 0 bit
// clears them. A set in the same cycle as a clear wins.
module tmr_flags #(
    parameter int unsigned NF = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic          we,
    input  logic [NF-1:0] wdata,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] keep;

    // Bits kept after a software write.
    always_comb keep = we ? wdata : '1;

    // Apply clear then set.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & keep) | set;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags & $past(set)) == $past(set)));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/cmp_timer.sv
// Module: top of the prescaled timer with compare flags. It joins the
// prescaler, counter, compare channels and flag register.
// Assumes the register fields are held stable by the driving logic.
module cmp_timer #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PSC_W = 16,
    parameter int unsigned NCH   = 4,
    localparam int unsigned NF   = NCH + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [1:0]           mode,
    input  logic                 dir_down,
    input  logic [PSC_W-1:0]     psc,
    input  logic [CNT_W-1:0]     reload,
    input  logic [NCH*CNT_W-1:0] cmp_val,
    input  logic                 sts_we,
    input  logic [NF-1:0]        sts_wdata,
    output logic [CNT_W-1:0]     count,
    output logic [NF-1:0]        flags
);
    import tmr_pkg::*;

    logic           tick, center, ovf, udf;
    logic [NCH-1:0] cset;
    logic [NF-1:0]  fset;

    always_comb center = is_center(mode);
    always_comb fset   = {cset, ovf | udf};

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(enable), .psc(psc), .tick(tick));

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .center(center),
        .dir_down(dir_down), .reload(reload), .cnt(count),
        .ovf_evt(ovf), .udf_evt(udf));

    tmr_compare #(.CNT_W(CNT_W), .NCH(NCH)) u_cmp (
        .tick(tick), .cnt(count), .cmp_vec(cmp_val), .reload(reload),
        .center(center), .dir_down(dir_down), .ovf_evt(ovf),
        .udf_evt(udf), .set(cset));

    tmr_flags #(.NF(NF)) u_flg (
        .clk(clk), .rst_n(rst_n), .set(fset), .we(sts_we),
        .wdata(sts_wdata), .flags(flags));

    a_r11_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !sts_we) |=> $stable(flags));
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        enable = 0;
    logic [1:0]  mode = 0;
    logic        dir_down = 0;
    logic [15:0] psc = 0;
    logic [15:0] reload = 0;
    logic [63:0] cmp_val = 0;
    logic        sts_we = 0;
    logic [4:0]  sts_wdata = 0;
    logic [15:0] count;
    logic [4:0]  flags;

    cmp_timer u_dut (.clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .dir_down(dir_down), .psc(psc), .reload(reload), .cmp_val(cmp_val),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .count(count), .flags(flags));

    always #2 clk = ~clk;  // 250 MHz

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string cur = "R1";
    bit    done = 0;

    // Behavioural reference model
    int m_pc = 0, m_cnt = 0, m_up = 1, m_fl = 0;

    always @(posedge clk) begin
        int tk, ov, un, s, nc, nu, cv, ctr;
        cyc++;
        if (!rst_n) begin
            m_pc = 0; m_cnt = 0; m_up = 1; m_fl = 0;
        end else begin
            tk = 0; ov = 0; un = 0; s = 0;
            ctr = (mode != 0);
            if (enable) begin
                if (m_pc >= psc) begin tk = 1; m_pc = 0; end
                else m_pc = m_pc + 1;
            end
            nc = m_cnt; nu = m_up;
            if (tk) begin
                if (ctr) begin
                    if (m_up) begin
                        if (m_cnt >= reload) begin
                            ov = 1;
                            if (reload == 0) nc = 0;
                            else begin nc = reload - 1; nu = 0; end
                        end else nc = m_cnt + 1;
                    end else if (m_cnt == 0) begin
                        un = 1; nc = (reload == 0) ? 0 : 1; nu = 1;
                    end else nc = m_cnt - 1;
                end else if (dir_down) begin
                    if (m_cnt == 0) begin un = 1; nc = reload; end
                    else nc = m_cnt - 1;
                end else begin
                    if (m_cnt >= reload) begin ov = 1; nc = 0; end
                    else nc = m_cnt + 1;
                end
            end
            if (!ctr) nu = 1;
            if (ov || un) s = 1;
            for (int k = 0; k < 4; k++) begin
                cv = cmp_val[16*k +: 16];
                if (ctr && cv == 0) ;
                else if (cv > reload) begin
                    if ((ctr || !dir_down) ? ov : un) s |= (1 << (k+1));
                end else if (tk && m_cnt == cv) s |= (1 << (k+1));
            end
            m_fl = (m_fl & (sts_we ? sts_wdata : 5'h1f)) | s;
            m_cnt = nc; m_up = nu;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) if (!done) begin
        chk({cur, " count"}, count, m_cnt);
        chk({cur, " flags"}, flags, m_fl);
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_all;
        sts_we = 1; sts_wdata = 0; @(negedge clk); sts_we = 0;
    endtask

    initial begin
        int c0, seen;
        // R1 reset
        cur = "R1";
        run(3);
        chk("R1 count zero", count, 0);
        chk("R1 flags zero", flags, 0);
        rst_n = 1;

        // R3 R6 R7: up counting
        cur = "R3 R6 R7";
        psc = 2; reload = 9; mode = 0; dir_down = 0;
        cmp_val = {16'd0, 16'd20, 16'd9, 16'd3};
        enable = 1;
        run(120);
        chk("R3 update flag set", flags[0], 1);
        chk("R7 over-range flag set", flags[3], 1);
        chk("R6 match flag set", flags[1], 1);

        // R9 write 1 keeps, write 0 clears
        cur = "R9";
        enable = 0;
        sts_we = 1; sts_wdata = 5'h1f; @(negedge clk); sts_we = 0;
        chk("R9 write-one keeps", flags, m_fl);
        sts_we = 1; sts_wdata = 5'h1e; @(negedge clk); sts_we = 0;
        chk("R9 bit0 cleared", flags[0], 0);
        clr_all;
        chk("R9 all cleared", flags, 0);

        // R4 R7 down counting
        cur = "R4 R7";
        dir_down = 1; enable = 1; psc = 1;
        run(120);
        chk("R4 underflow flag", flags[0], 1);

        // R5 R8 center counting
        cur = "R5 R8 R6";
        clr_all;
        mode = 1; psc = 0; reload = 6;
        cmp_val = {16'd10, 16'd3, 16'd6, 16'd0};
        run(200);
        chk("R8 zero compare silent in center", flags[1], 0);
        chk("R5 update flag", flags[0], 1);
        chk("R7 over-range in center", flags[4], 1);

        // center with mode 11, dir_down ignored
        cur = "R5";
        clr_all;
        mode = 2'b11; dir_down = 0;
        run(80);
        chk("R5 mode 11 center", flags[1], 0);

        // R11 freeze
        cur = "R11";
        clr_all;
        enable = 0;
        @(negedge clk);
        c0 = count;
        run(20);
        chk("R11 count frozen", count, c0);
        chk("R11 no flags", flags, 0);
        enable = 1;

        // R10 set beats continuous clear
        cur = "R10";
        sts_we = 1; sts_wdata = 0; seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (flags != 0) seen++;
        end
        sts_we = 0;
        chk("R10 flags seen under clear", seen > 0, 1);

        // R2 maximal prescale
        cur = "R2";
        rst_n = 0; run(2); rst_n = 1;
        mode = 0; dir_down = 0; reload = 100; psc = 16'hffff; enable = 1;
        repeat (65535) @(posedge clk);
        @(negedge clk);
        chk("R2 no advance before P+1", count, 0);
        @(negedge clk);
        chk("R2 advance after P+1", count, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule